// File: doc/BRIEF.md
# Pedal Converter Start/Read Sequencer

This block drives an external 8-bit successive-approximation converter that has three active-low pins: a start strobe, an output enable and a completion flag. The conversion result is shown to the host as a ready bit and a data byte. The host never starts a conversion itself. After reset the block launches one conversion on its own. After every accepted host read it launches the next conversion, so a fresh sample is always on its way.

A host read is a one-cycle strobe. The block drives the output enable low for a fixed number of clocks and captures the converter byte on the last of them. It then returns the byte with a one-cycle valid pulse. Once the enable is back high, the block waits one idle cycle and then drives the start strobe low for a programmable number of clocks, never fewer than two. The completion flag passes through a two-flop synchronizer before it can set the ready bit. A watchdog counter raises a timeout flag if completion does not arrive in time.

Top module: `pedalAdcSeq`

## Requirements
- R1: While reset is held, adcWrN and adcRdN are high and adcReady, adcTimeout and hostValid are 0.
- R2: After reset is released, a start pulse appears on adcWrN without any host read, one cycle after the release.
- R3: Each start pulse holds adcWrN low for exactly max(START_CYCLES, 2) consecutive clocks.
- R4: adcReady rises on the third rising clock edge after adcIntrN is first sampled low during a conversion, and not earlier. The two edges before it pass through the synchronizer.
- R5: An accepted hostRd holds adcRdN low for exactly READ_CYCLES clocks, starting the cycle after the strobe. In the first cycle after adcRdN returns high, hostValid is 1 for one cycle and hostData equals the 8-bit adcData value sampled on the last low cycle.
- R6: adcReady is 0 from the first cycle in which adcRdN is low.
- R7: After each read, adcWrN goes low exactly one cycle after adcRdN returns high, and the two pins are never low together.
- R8: adcTimeout becomes 1 exactly TIMEOUT_CYCLES clocks after adcWrN falls if adcIntrN has not been seen low. It stays set until the next start pulse begins, and it is 0 during that start pulse.
- R9: A hostRd strobe that arrives while a start pulse is in progress is ignored. adcRdN stays high and hostValid stays 0.
- R10: Converter values across the whole unsigned range 0x00 to 0xFF reach hostData unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hostRd | input | 1 | One-cycle host read request |
| hostData | output | DATA_W | Captured conversion result |
| hostValid | output | 1 | One-cycle pulse, hostData is new |
| adcReady | output | 1 | Status bit: a finished result is waiting |
| adcTimeout | output | 1 | Status bit: conversion overdue |
| adcWrN | output | 1 | Converter start strobe, active low |
| adcRdN | output | 1 | Converter output enable, active low |
| adcIntrN | input | 1 | Converter completion flag, active low, asynchronous |
| adcData | input | DATA_W | Converter data bus |

## Verification
The bench behaves like a converter. It answers each start pulse after a chosen delay and releases its completion flag when the output enable falls. It measures every pulse width and the gap between the enable and the next start. A design that overlapped the two strobes, or shortened the start pulse, would fail the gap and width counts.

The bench checks the ready bit on each of the three edges after completion. A missing synchronizer stage would show the bit one edge early, and a design that kept ready through the read would fail the check in the first enable cycle.

A conversion that never completes is timed against the timeout window edge by edge, and the flag must be clear again once the next start begins. A read strobe dropped into a start pulse must leave the enable untouched. Otherwise the design would read a half-started conversion.

// File: rtl/pedalAdcPkg.sv
package pedalAdcPkg;

  typedef enum logic [2:0] {
    ST_LAUNCH,
    ST_START,
    ST_WAIT,
    ST_IDLE,
    ST_READ,
    ST_GAP
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic clrReady;
    logic waitPhase;
    logic setTimeout;
    logic clrTimeout;
  } adcStrobe_t;

endpackage

// File: rtl/pedalAdcCtrl.sv
module pedalAdcCtrl
  import pedalAdcPkg::*;
#(
  parameter int START_CYCLES   = 4,
  parameter int READ_CYCLES    = 2,
  parameter int TIMEOUT_CYCLES = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hostRd,
  input  logic       intrSeen,
  output adcStrobe_t strobe,
  output logic       wrN,
  output logic       rdN
);

  localparam int WR_LEN = (START_CYCLES < 2) ? 2 : START_CYCLES;
  localparam int RD_LEN = (READ_CYCLES < 1) ? 1 : READ_CYCLES;
  localparam int CNT_MAX = (WR_LEN > RD_LEN) ? WR_LEN : RD_LEN;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

  seqState_t state;
  logic [CNT_W-1:0] phaseCnt;
  logic [TMR_W-1:0] waitTmr;
  logic hostAccept;
  logic wrLast;
  logic rdLast;
  logic tmrEnd;

  assign hostAccept = hostRd && (state == ST_IDLE || state == ST_WAIT);
  assign wrLast = (phaseCnt == CNT_W'(WR_LEN - 1));
  assign rdLast = (phaseCnt == CNT_W'(RD_LEN - 1));
  assign tmrEnd = (waitTmr == TMR_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LAUNCH;
      phaseCnt <= '0;
      waitTmr <= '0;
    end else begin
      case (state)
        ST_LAUNCH: begin
          state <= ST_START;
          phaseCnt <= '0;
          waitTmr <= '0;
        end
        ST_START: begin
          phaseCnt <= phaseCnt + 1'b1;
          if (!tmrEnd) waitTmr <= waitTmr + 1'b1;
          if (wrLast) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!tmrEnd) waitTmr <= waitTmr + 1'b1;
          if (hostAccept) begin
            state <= ST_READ;
            phaseCnt <= '0;
          end else if (intrSeen) begin
            state <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (hostAccept) begin
            state <= ST_READ;
            phaseCnt <= '0;
          end
        end
        ST_READ: begin
          phaseCnt <= phaseCnt + 1'b1;
          if (rdLast) state <= ST_GAP;
        end
        ST_GAP: begin
          state <= ST_START;
          phaseCnt <= '0;
          waitTmr <= '0;
        end
        default: state <= ST_LAUNCH;
      endcase
    end
  end

  always_comb begin
    strobe.capture    = (state == ST_READ) && rdLast;
    strobe.clrReady   = hostAccept;
    strobe.waitPhase  = (state == ST_WAIT);
    strobe.setTimeout = (state == ST_WAIT) && tmrEnd && !intrSeen;
    strobe.clrTimeout = (state == ST_LAUNCH) || (state == ST_GAP);
  end

  assign wrN = (state != ST_START);
  assign rdN = (state != ST_READ);

  // R3
  wr_min_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wrN) |=> !wrN);

  // R7
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wrN) |-> $past(rdN));

  // R7
  no_strobe_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(!wrN && !rdN));

endmodule

// File: rtl/pedalAdcPath.sv
module pedalAdcPath
  import pedalAdcPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  adcStrobe_t        strobe,
  input  logic              adcIntrN,
  input  logic [DATA_W-1:0] adcData,
  output logic              intrSeen,
  output logic              ready,
  output logic              timedOut,
  output logic [DATA_W-1:0] hostData,
  output logic              hostValid
);

  logic syncA;
  logic syncB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= adcIntrN;
      syncB <= syncA;
    end
  end

  assign intrSeen = !syncB;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      timedOut <= 1'b0;
      hostData <= '0;
      hostValid <= 1'b0;
    end else begin
      if (strobe.clrReady) ready <= 1'b0;
      else if (strobe.waitPhase && intrSeen) ready <= 1'b1;

      if (strobe.clrTimeout) timedOut <= 1'b0;
      else if (strobe.setTimeout) timedOut <= 1'b1;

      hostValid <= strobe.capture;
      if (strobe.capture) hostData <= adcData;
    end
  end

  // R4
  ready_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (!$past(adcIntrN, 2) && !$past(adcIntrN, 1)));

  // R8
  timeout_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timedOut) |-> !ready);

endmodule

// File: rtl/pedalAdcSeq.sv
module pedalAdcSeq
  import pedalAdcPkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int START_CYCLES   = 4,
  parameter int READ_CYCLES    = 2,
  parameter int TIMEOUT_CYCLES = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostData,
  output logic              hostValid,
  output logic              adcReady,
  output logic              adcTimeout,
  output logic              adcWrN,
  output logic              adcRdN,
  input  logic              adcIntrN,
  input  logic [DATA_W-1:0] adcData
);

  adcStrobe_t strobe;
  logic intrSeen;

  pedalAdcCtrl #(
    .START_CYCLES  (START_CYCLES),
    .READ_CYCLES   (READ_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) ctrl (
    .clk     (clk),
    .rst     (rst),
    .hostRd  (hostRd),
    .intrSeen(intrSeen),
    .strobe  (strobe),
    .wrN     (adcWrN),
    .rdN     (adcRdN)
  );

  pedalAdcPath #(
    .DATA_W(DATA_W)
  ) path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .adcIntrN (adcIntrN),
    .adcData  (adcData),
    .intrSeen (intrSeen),
    .ready    (adcReady),
    .timedOut (adcTimeout),
    .hostData (hostData),
    .hostValid(hostValid)
  );

  // R6
  ready_clear_on_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adcRdN) |-> !adcReady);

  // R5
  valid_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    hostValid |-> ($past(adcRdN) == 1'b0 && adcRdN));

endmodule

// File: tb/pedalAdcSeq_test.sv
module pedalAdcSeq_test;

  localparam int CLK_PERIOD = 10;
  localparam int WR_CYC = 3;
  localparam int RD_CYC = 2;
  localparam int TO_CYC = 40;
  localparam int NVEC = 6;
  // each entry: {converter value, cycles from end of start pulse to completion}
  localparam logic [15:0] VECS [NVEC] = '{
    16'h00_05, 16'hFF_02, 16'h5A_0C, 16'h01_00, 16'h80_14, 16'hA5_07
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostRd = 1'b0;
  logic adcIntrN = 1'b1;
  logic [7:0] adcData = 8'h00;
  logic [7:0] hostData;
  logic hostValid, adcReady, adcTimeout, adcWrN, adcRdN;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pedalAdcSeq #(
    .DATA_W(8), .START_CYCLES(WR_CYC), .READ_CYCLES(RD_CYC), .TIMEOUT_CYCLES(TO_CYC)
  ) uut (
    .clk(clk), .rst(rst), .hostRd(hostRd), .hostData(hostData), .hostValid(hostValid),
    .adcReady(adcReady), .adcTimeout(adcTimeout), .adcWrN(adcWrN), .adcRdN(adcRdN),
    .adcIntrN(adcIntrN), .adcData(adcData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // counts cycles of adcWrN high before the start pulse, then its low width
  task automatic startPulse(output int gap, output int width);
    gap = 0;
    while (adcWrN) begin gap++; @(negedge clk); end
    width = 0;
    while (!adcWrN) begin width++; @(negedge clk); end
  endtask

  task automatic finishConv(input logic [7:0] val, input int delay);
    repeat (delay) @(negedge clk);
    adcData = val;
    adcIntrN = 1'b0;
    @(negedge clk);
    check("R4 ready after 1 edge", 32'(adcReady), 32'h0);
    @(negedge clk);
    check("R4 ready after 2 edges", 32'(adcReady), 32'h0);
    @(negedge clk);
    check("R4 ready after 3 edges", 32'(adcReady), 32'h1);
  endtask

  task automatic hostRead(input logic [7:0] val);
    int w;
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    check("R6 ready cleared with rd", 32'(adcReady), 32'h0);
    adcIntrN = 1'b1;
    w = 0;
    while (!adcRdN) begin
      w++;
      check("R7 no overlap", 32'(adcWrN), 32'h1);
      @(negedge clk);
    end
    adcData = ~val;
    check("R5 rd width", 32'(w), 32'(RD_CYC));
    check("R5 valid pulse", 32'(hostValid), 32'h1);
    check("R10 data value", 32'(hostData), 32'(val));
  endtask

  initial begin
    int gap, width;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 wrN in reset", 32'(adcWrN), 32'h1);
    check("R1 rdN in reset", 32'(adcRdN), 32'h1);
    check("R1 ready in reset", 32'(adcReady), 32'h0);
    check("R1 timeout in reset", 32'(adcTimeout), 32'h0);
    check("R1 valid in reset", 32'(hostValid), 32'h0);
    rst = 1'b0;

    // R2 automatic start after reset
    startPulse(gap, width);
    check("R2 auto start gap", 32'(gap), 32'h1);
    check("R3 wr width first", 32'(width), 32'(WR_CYC));

    for (int i = 0; i < NVEC; i++) begin
      if (i > 0) begin
        startPulse(gap, width);
        check("R7 gap rd to wr", 32'(gap), 32'h1);
        check("R3 wr width", 32'(width), 32'(WR_CYC));
      end
      finishConv(VECS[i][15:8], int'(VECS[i][7:0]));
      check("R8 no timeout", 32'(adcTimeout), 32'h0);
      hostRead(VECS[i][15:8]);
    end

    // R9 read during start pulse is ignored
    while (adcWrN) @(negedge clk);
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    for (int k = 0; k < WR_CYC + 2; k++) begin
      check("R9 rdN stays high", 32'(adcRdN), 32'h1);
      check("R9 no valid", 32'(hostValid), 32'h0);
      @(negedge clk);
    end
    finishConv(8'h3C, 1);
    hostRead(8'h3C);

    // R8 timeout window, measured from the falling start strobe
    while (adcWrN) @(negedge clk);
    repeat (TO_CYC - 1) @(negedge clk);
    check("R8 timeout not yet", 32'(adcTimeout), 32'h0);
    @(negedge clk);
    check("R8 timeout set", 32'(adcTimeout), 32'h1);
    check("R8 not ready", 32'(adcReady), 32'h0);
    repeat (3) @(negedge clk);
    check("R8 timeout sticky", 32'(adcTimeout), 32'h1);
    finishConv(8'hC3, 0);
    hostRead(8'hC3);
    while (adcWrN) @(negedge clk);
    check("R8 timeout cleared at start", 32'(adcTimeout), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule